// File: doc/BRIEF.md
# Context-Tagged Translation Cache

This block is a small, fully associative cache of address translations. Each entry maps a virtual page number to a physical frame number. Each entry also carries two tags that decide whether it may answer a lookup. The first is the process context it was filled under. The second is a protection domain number. Because the context tag is part of the match, mappings belonging to several processes can stay resident side by side. A context switch then only rewrites two small registers instead of emptying the whole cache.

A lookup is purely combinational and returns hit and frame in the same cycle. A fill writes one entry per clock and stamps it with the context register's current value. The slot for a fill is chosen in this order: an existing entry with the same page and context, otherwise the lowest empty slot, otherwise a round-robin victim. A flush input empties the cache.

Top module: `ctlb_top`

## Requirements
- R1: A lookup is combinational. When a valid entry qualifies, `look_hit_o` is 1 and `look_pfn_o` carries that entry's frame in the same cycle. When none qualifies, `look_hit_o` is 0 and `look_pfn_o` is 0.
- R2: `flush_i` high at a clock edge invalidates every entry and returns the replacement pointer to slot 0. A fill in the same cycle is dropped.
- R3: An entry qualifies only if its context tag equals the current context register. `ctx_we_i` loads that register from `ctx_i` at the clock edge, so the new value governs lookups from the next cycle on.
- R4: A fill stores the context register value held at the fill's clock edge as the entry's tag. Fill data carries no context.
- R5: The same page number filled under two different contexts occupies two entries. Each context sees only its own frame.
- R6: An entry qualifies only if bit d of the domain mask is 1, where d is the entry's 4-bit domain. `dmask_we_i` loads the mask from `dmask_i` at the clock edge. A mask change alters lookup results from the next cycle without rewriting any entry.
- R7: When no entry matches, a fill goes to the lowest-index invalid slot. When all slots are valid, it goes to the slot named by a round-robin pointer. The pointer starts at 0, advances by one (wrapping after the last slot) only when it is used, and is not moved by fills into empty slots.
- R8: A fill whose page and context equal those of a valid entry overwrites that entry's frame and domain in place and takes no new slot.
- R9: While `rst_n` is low, all entries become invalid, the context register becomes 0, the domain mask becomes all ones and the pointer becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| ctx_we_i | input | 1 | Load the current context register |
| ctx_i | input | 8 | New current context value |
| dmask_we_i | input | 1 | Load the domain access mask |
| dmask_i | input | 16 | New domain access mask, bit d enables domain d |
| fill_en_i | input | 1 | Write one translation |
| fill_vpn_i | input | 20 | Virtual page of the fill |
| fill_pfn_i | input | 20 | Physical frame of the fill |
| fill_dom_i | input | 4 | Domain of the fill |
| look_vpn_i | input | 20 | Virtual page to translate |
| look_hit_o | output | 1 | A qualifying entry was found |
| look_pfn_o | output | 20 | Frame of the hit entry, 0 on a miss |

## Verification
The bench fills one page under two contexts and checks that each context sees only its own frame. A design that ignored the tag would return the wrong process's frame. It clears one domain bit, then checks that the entry misses and comes back once the bit is set again. A design that rewrote or dropped entries on a mask change would not recover. It refills a resident page and then fills the cache to capacity. A design that took a fresh slot for the refill would lose the page to the first eviction. It also checks the eviction order across the pointer's advance, and that a fill arriving together with a flush leaves nothing behind.

// File: rtl/ctlb_pkg.sv
package ctlb_pkg;

  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_VPN_W   = 20;
  localparam int unsigned DEF_PFN_W   = 20;
  localparam int unsigned DEF_CTX_W   = 8;
  localparam int unsigned DEF_DOM_W   = 4;

  typedef enum logic [1:0] {
    SLOT_NONE   = 2'd0,
    SLOT_MATCH  = 2'd1,
    SLOT_FREE   = 2'd2,
    SLOT_VICTIM = 2'd3
  } slot_kind_e;

  // Round-robin successor of a slot index for a cache of n slots.
  function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/ctlb_lowest.sv
module ctlb_lowest #(
  parameter int unsigned N    = 8,
  parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  output logic            found_o,
  output logic [IDXW-1:0] idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/ctlb_match_array.sv
module ctlb_match_array #(
  parameter int unsigned N     = 8,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned CTX_W = 8,
  parameter int unsigned DOM_W = 4,
  localparam int unsigned DOM_N = 1 << DOM_W
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][VPN_W-1:0] vpn_i,
  input  logic [N-1:0][CTX_W-1:0] ctx_i,
  input  logic [N-1:0][DOM_W-1:0] dom_i,
  input  logic [CTX_W-1:0]        cur_ctx_i,
  input  logic [DOM_N-1:0]        dmask_i,
  input  logic [VPN_W-1:0]        look_vpn_i,
  input  logic [VPN_W-1:0]        fill_vpn_i,
  output logic [N-1:0]            qual_o,
  output logic [N-1:0]            fmatch_o
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic ctx_ok;
    logic dom_ok;
    assign ctx_ok      = (ctx_i[g] == cur_ctx_i);
    assign dom_ok      = dmask_i[dom_i[g]];
    assign qual_o[g]   = valid_i[g] && ctx_ok && dom_ok && (vpn_i[g] == look_vpn_i);
    assign fmatch_o[g] = valid_i[g] && ctx_ok && (vpn_i[g] == fill_vpn_i);
  end

endmodule

// File: rtl/ctlb_rr_ptr.sv
module ctlb_rr_ptr
  import ctlb_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            advance_i,
  output logic [IDXW-1:0] ptr_o
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      ptr_o <= '0;
    end else if (advance_i) begin
      ptr_o <= IDXW'(rr_next(int'(ptr_o), N));
    end
  end

endmodule

// File: rtl/ctlb_top.sv
module ctlb_top
  import ctlb_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned VPN_W   = DEF_VPN_W,
  parameter int unsigned PFN_W   = DEF_PFN_W,
  parameter int unsigned CTX_W   = DEF_CTX_W,
  parameter int unsigned DOM_W   = DEF_DOM_W,
  localparam int unsigned DOM_N  = 1 << DOM_W,
  localparam int unsigned IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             ctx_we_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic             dmask_we_i,
  input  logic [DOM_N-1:0] dmask_i,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic [DOM_W-1:0] fill_dom_i,
  input  logic [VPN_W-1:0] look_vpn_i,
  output logic             look_hit_o,
  output logic [PFN_W-1:0] look_pfn_o
);

  // Entry storage
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic [ENTRIES-1:0][CTX_W-1:0] ctx_q;
  logic [ENTRIES-1:0][DOM_W-1:0] dom_q;

  // Control registers
  logic [CTX_W-1:0] cur_ctx_q;
  logic [DOM_N-1:0] dmask_q;

  // Named internal events
  logic [ENTRIES-1:0] qual_vec;
  logic [ENTRIES-1:0] fmatch_vec;
  logic               hit_found;
  logic [IDXW-1:0]    hit_idx;
  logic               m_found;
  logic [IDXW-1:0]    m_idx;
  logic               f_found;
  logic [IDXW-1:0]    f_idx;
  logic [IDXW-1:0]    rr_ptr;
  logic               fill_take;
  logic               victim_used;
  logic [IDXW-1:0]    slot_idx;
  slot_kind_e         slot_kind;
  logic [CTX_W-1:0]   hit_ctx;
  logic [DOM_W-1:0]   hit_dom;

  ctlb_match_array #(
    .N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .DOM_W(DOM_W)
  ) u_match (
    .valid_i   (valid_q),
    .vpn_i     (vpn_q),
    .ctx_i     (ctx_q),
    .dom_i     (dom_q),
    .cur_ctx_i (cur_ctx_q),
    .dmask_i   (dmask_q),
    .look_vpn_i(look_vpn_i),
    .fill_vpn_i(fill_vpn_i),
    .qual_o    (qual_vec),
    .fmatch_o  (fmatch_vec)
  );

  ctlb_lowest #(.N(ENTRIES), .IDXW(IDXW)) u_hit_pick (
    .req_i  (qual_vec),
    .found_o(hit_found),
    .idx_o  (hit_idx)
  );

  ctlb_lowest #(.N(ENTRIES), .IDXW(IDXW)) u_match_pick (
    .req_i  (fmatch_vec),
    .found_o(m_found),
    .idx_o  (m_idx)
  );

  ctlb_lowest #(.N(ENTRIES), .IDXW(IDXW)) u_free_pick (
    .req_i  (~valid_q),
    .found_o(f_found),
    .idx_o  (f_idx)
  );

  ctlb_rr_ptr #(.N(ENTRIES), .IDXW(IDXW)) u_rr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (flush_i),
    .advance_i(victim_used),
    .ptr_o    (rr_ptr)
  );

  // Lookup result
  assign look_hit_o = hit_found;
  assign look_pfn_o = hit_found ? pfn_q[hit_idx] : '0;
  assign hit_ctx    = ctx_q[hit_idx];
  assign hit_dom    = dom_q[hit_idx];

  // Fill slot selection: match, then free, then victim
  assign fill_take = fill_en_i && !flush_i;

  always_comb begin
    if (!fill_take) begin
      slot_kind = SLOT_NONE;
      slot_idx  = '0;
    end else if (m_found) begin
      slot_kind = SLOT_MATCH;
      slot_idx  = m_idx;
    end else if (f_found) begin
      slot_kind = SLOT_FREE;
      slot_idx  = f_idx;
    end else begin
      slot_kind = SLOT_VICTIM;
      slot_idx  = rr_ptr;
    end
  end

  assign victim_used = (slot_kind == SLOT_VICTIM);

  // Control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ctx_q <= '0;
      dmask_q   <= '1;
    end else begin
      if (ctx_we_i)   cur_ctx_q <= ctx_i;
      if (dmask_we_i) dmask_q   <= dmask_i;
    end
  end

  // Valid bits
  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      valid_q <= '0;
    end else if (slot_kind != SLOT_NONE) begin
      valid_q[slot_idx] <= 1'b1;
    end
  end

  // Entry payload, no reset needed
  always_ff @(posedge clk) begin
    if (rst_n && slot_kind != SLOT_NONE) begin
      vpn_q[slot_idx] <= fill_vpn_i;
      pfn_q[slot_idx] <= fill_pfn_i;
      ctx_q[slot_idx] <= cur_ctx_q;
      dom_q[slot_idx] <= fill_dom_i;
    end
  end

endmodule

// File: rtl/ctlb_checker.sv
module ctlb_checker #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned CTX_W   = 8,
  parameter int unsigned DOM_W   = 4,
  localparam int unsigned DOM_N  = 1 << DOM_W,
  localparam int unsigned IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic               fill_take,
  input logic               m_found,
  input logic               victim_used,
  input logic [IDXW-1:0]    rr_ptr,
  input logic [ENTRIES-1:0] valid_q,
  input logic [CTX_W-1:0]   cur_ctx_q,
  input logic [DOM_N-1:0]   dmask_q,
  input logic [ENTRIES-1:0] qual_vec,
  input logic               look_hit_o,
  input logic [PFN_W-1:0]   look_pfn_o,
  input logic [CTX_W-1:0]   hit_ctx,
  input logic [DOM_W-1:0]   hit_dom
);

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !look_hit_o |-> look_pfn_o == '0); // R1

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> valid_q == '0); // R2

  AST_HIT_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    look_hit_o |-> hit_ctx == cur_ctx_q); // R3

  AST_SINGLE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(qual_vec)); // R5

  AST_HIT_DOM: assert property (@(posedge clk) disable iff (!rst_n)
    look_hit_o |-> dmask_q[hit_dom]); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    victim_used |=> rr_ptr == (($past(rr_ptr) == IDXW'(ENTRIES - 1)) ? '0 : $past(rr_ptr) + 1'b1)); // R7

  AST_OVERWRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_take && m_found) |=> $stable(valid_q)); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (valid_q == '0 && cur_ctx_q == '0 && dmask_q == '1 && rr_ptr == '0)); // R9

endmodule

bind ctlb_top ctlb_checker #(
  .ENTRIES(ENTRIES), .PFN_W(PFN_W), .CTX_W(CTX_W), .DOM_W(DOM_W)
) u_ctlb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush_i    (flush_i),
  .fill_take  (fill_take),
  .m_found    (m_found),
  .victim_used(victim_used),
  .rr_ptr     (rr_ptr),
  .valid_q    (valid_q),
  .cur_ctx_q  (cur_ctx_q),
  .dmask_q    (dmask_q),
  .qual_vec   (qual_vec),
  .look_hit_o (look_hit_o),
  .look_pfn_o (look_pfn_o),
  .hit_ctx    (hit_ctx),
  .hit_dom    (hit_dom)
);

// File: tb/tb_ctlb_top.sv
module tb_ctlb_top;

  localparam logic [2:0] OP_FILL = 3'd1;
  localparam logic [2:0] OP_LOOK = 3'd2;
  localparam logic [2:0] OP_CTX  = 3'd3;
  localparam logic [2:0] OP_DOM  = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [19:0] vpn;
    logic [19:0] pfn;
    logic [3:0]  dom;
    logic [15:0] val;
    logic        ehit;
    logic [19:0] epfn;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{OP_FILL, 20'h00010, 20'h0AAAA, 4'd1, 16'h0000, 1'b0, 20'h0,     8'd4},
    '{OP_LOOK, 20'h00010, 20'h0,     4'd0, 16'h0000, 1'b1, 20'h0AAAA, 8'd1},
    '{OP_LOOK, 20'h00011, 20'h0,     4'd0, 16'h0000, 1'b0, 20'h0,     8'd1},
    '{OP_CTX,  20'h0,     20'h0,     4'd0, 16'h0005, 1'b0, 20'h0,     8'd3},
    '{OP_LOOK, 20'h00010, 20'h0,     4'd0, 16'h0000, 1'b0, 20'h0,     8'd3},
    '{OP_FILL, 20'h00010, 20'h0BBBB, 4'd2, 16'h0000, 1'b0, 20'h0,     8'd5},
    '{OP_LOOK, 20'h00010, 20'h0,     4'd0, 16'h0000, 1'b1, 20'h0BBBB, 8'd4},
    '{OP_CTX,  20'h0,     20'h0,     4'd0, 16'h0000, 1'b0, 20'h0,     8'd3},
    '{OP_LOOK, 20'h00010, 20'h0,     4'd0, 16'h0000, 1'b1, 20'h0AAAA, 8'd5},
    '{OP_DOM,  20'h0,     20'h0,     4'd0, 16'hFFFD, 1'b0, 20'h0,     8'd6},
    '{OP_LOOK, 20'h00010, 20'h0,     4'd0, 16'h0000, 1'b0, 20'h0,     8'd6},
    '{OP_DOM,  20'h0,     20'h0,     4'd0, 16'hFFFF, 1'b0, 20'h0,     8'd6},
    '{OP_LOOK, 20'h00010, 20'h0,     4'd0, 16'h0000, 1'b1, 20'h0AAAA, 8'd6},
    '{OP_FILL, 20'h00010, 20'h0CCCC, 4'd3, 16'h0000, 1'b0, 20'h0,     8'd8},
    '{OP_LOOK, 20'h00010, 20'h0,     4'd0, 16'h0000, 1'b1, 20'h0CCCC, 8'd8},
    '{OP_DOM,  20'h0,     20'h0,     4'd0, 16'hFFF7, 1'b0, 20'h0,     8'd8},
    '{OP_LOOK, 20'h00010, 20'h0,     4'd0, 16'h0000, 1'b0, 20'h0,     8'd8},
    '{OP_DOM,  20'h0,     20'h0,     4'd0, 16'hFFFF, 1'b0, 20'h0,     8'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i, ctx_we_i, dmask_we_i, fill_en_i;
  logic [7:0]  ctx_i;
  logic [15:0] dmask_i;
  logic [19:0] fill_vpn_i, fill_pfn_i, look_vpn_i;
  logic [3:0]  fill_dom_i;
  logic        look_hit_o;
  logic [19:0] look_pfn_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ctlb_top dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .ctx_we_i(ctx_we_i), .ctx_i(ctx_i),
    .dmask_we_i(dmask_we_i), .dmask_i(dmask_i),
    .fill_en_i(fill_en_i), .fill_vpn_i(fill_vpn_i),
    .fill_pfn_i(fill_pfn_i), .fill_dom_i(fill_dom_i),
    .look_vpn_i(look_vpn_i), .look_hit_o(look_hit_o), .look_pfn_o(look_pfn_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    flush_i = 1'b0; ctx_we_i = 1'b0; dmask_we_i = 1'b0; fill_en_i = 1'b0;
    ctx_i = '0; dmask_i = '0; fill_vpn_i = '0; fill_pfn_i = '0; fill_dom_i = '0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic ehit,
                      input logic [19:0] epfn, input string rq);
    look_vpn_i = vpn;
    #1;
    checks++;
    if (look_hit_o !== ehit || look_pfn_o !== epfn) begin
      errors++;
      $display("FAIL %s vpn=%h: hit=%b pfn=%h expected hit=%b pfn=%h",
               rq, vpn, look_hit_o, look_pfn_o, ehit, epfn);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [3:0] dom);
    fill_en_i = 1'b1; fill_vpn_i = vpn; fill_pfn_i = pfn; fill_dom_i = dom;
    tick();
    fill_en_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_inputs();
    look_vpn_i = '0;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;

    // R9: empty after reset
    look(20'h00000, 1'b0, 20'h0, "R9");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].req);
      case (VEC[i].op)
        OP_FILL: fill(VEC[i].vpn, VEC[i].pfn, VEC[i].dom);
        OP_CTX: begin
          ctx_we_i = 1'b1; ctx_i = VEC[i].val[7:0];
          tick();
          ctx_we_i = 1'b0;
        end
        OP_DOM: begin
          dmask_we_i = 1'b1; dmask_i = VEC[i].val;
          tick();
          dmask_we_i = 1'b0;
        end
        default: look(VEC[i].vpn, VEC[i].ehit, VEC[i].epfn, rq);
      endcase
    end

    // R2: flush empties everything
    flush_i = 1'b1; tick(); flush_i = 1'b0;
    look(20'h00010, 1'b0, 20'h0, "R2");

    // R8 + R7: overwrite takes no slot, then fill to capacity
    fill(20'h00100, 20'h11111, 4'd0);
    fill(20'h00100, 20'h22222, 4'd0);
    for (int k = 1; k < 8; k++) fill(20'h00100 + 20'(k), 20'h30000 + 20'(k), 4'd0);
    look(20'h00100, 1'b1, 20'h22222, "R8");
    look(20'h00107, 1'b1, 20'h30007, "R7");
    fill(20'h00200, 20'h40000, 4'd0);
    look(20'h00100, 1'b0, 20'h0, "R7");
    look(20'h00200, 1'b1, 20'h40000, "R7");
    look(20'h00101, 1'b1, 20'h30001, "R7");
    fill(20'h00201, 20'h40001, 4'd0);
    look(20'h00101, 1'b0, 20'h0, "R7");
    look(20'h00102, 1'b1, 20'h30002, "R7");

    // R4: fill in the same cycle as a context write uses the old context
    ctx_we_i = 1'b1; ctx_i = 8'h09;
    fill(20'h00300, 20'h50000, 4'd0);
    ctx_we_i = 1'b0;
    look(20'h00300, 1'b0, 20'h0, "R4");
    ctx_we_i = 1'b1; ctx_i = 8'h00; tick(); ctx_we_i = 1'b0;
    look(20'h00300, 1'b1, 20'h50000, "R4");

    // R2: flush beats a simultaneous fill
    flush_i = 1'b1;
    fill(20'h00400, 20'h60000, 4'd0);
    flush_i = 1'b0;
    look(20'h00400, 1'b0, 20'h0, "R2");
    look(20'h00200, 1'b0, 20'h0, "R2");

    // R9: reset mid-run clears entries and restores context and mask
    fill(20'h00500, 20'h70000, 4'd15);
    ctx_we_i = 1'b1; ctx_i = 8'h33; dmask_we_i = 1'b1; dmask_i = 16'h0001;
    tick();
    ctx_we_i = 1'b0; dmask_we_i = 1'b0;
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    look(20'h00500, 1'b0, 20'h0, "R9");
    fill(20'h00600, 20'h71111, 4'd15);
    look(20'h00600, 1'b1, 20'h71111, "R9");

    finish_run();
  end

endmodule